// File: doc/BRIEF.md
# Split Dual 8-bit PWM Timer

This block holds two 8-bit down-counters, called low and high, and builds eight single-slope PWM waveforms from them. Both counters advance on one shared count tick. The tick comes either from a divided system clock or from an external event strobe. Each counter has its own period register and its own four compare registers, so every one of the eight outputs has its own duty cycle.

Each counter gives a one-cycle underflow pulse when it wraps. Only the four low-counter channels report compare matches. Each of those channels has a sticky flag and a one-cycle event pulse, and the pulse is meant to drive an interrupt or DMA request. The high-counter compares drive waveforms only.

Software reaches the block through a plain write port of address, data and enable. The port has no back-pressure: a write is taken on every clock edge where `wr_en` is high. There is no streaming data path, so every pin is plain control or status.

Top module: `spt_dual_pwm`

## Requirements
- R1: Synchronous active-high `rst` clears both counters, every compare register and every flag. It sets both period registers to 8'hFF and selects clock source 0 (stopped). Right after reset, all eight PWM outputs are high, because 0 <= 0.
- R2: On each tick, a counter above zero decrements by one. A counter at zero reloads from its period register on that tick. No mode counts up.
- R3: A tick that finds a counter at zero raises that counter's underflow output (`unf_lo` or `unf_hi`) for exactly the following cycle. The two counters do this independently.
- R4: A PWM output is high while its counter is less than or equal to its compare value, and low otherwise. Outputs 0 to 3 of `pwm_lo` use the low counter, and the same bits of `pwm_hi` use the high counter.
- R5: A compare value of 0 gives a high pulse lasting one tick in each period. A compare value above the period keeps the output high.
- R6: With a source code of 0, or any code from 9 to 15, the counters never advance, and event strobes are ignored.
- R7: Source codes 1 to 7 divide the clock by 1, 2, 4, 8, 64, 256 and 1024. The divider restarts at zero when the source leaves the stopped state. The first tick therefore comes N cycles after the write, and later ticks come every N cycles.
- R8: Source code 8 advances both counters once on each clock where `evt_strobe` is high.
- R9: A tick can move the low counter to a value that equals the compare value of channel c. When that happens, `cmp_flag[c]` sets one cycle later and stays set. In the same cycle, `cmp_evt[c]` pulses high for one cycle.
- R10: Writing a 1 to bit c at address 1 clears `cmp_flag[c]`. If a set and a clear land in the same cycle, the set wins.
- R11: A match on a high-counter compare never changes `cmp_flag` or `cmp_evt`.
- R12: A write takes effect on its own clock edge. Address 0 holds the source code in data bits [3:0]. Address 2 loads the low counter and address 3 loads the high counter; a load takes priority over a tick. Address 4 is the low period and address 5 the high period. Addresses 8 to 11 are the low compares for channels 0 to 3, and addresses 12 to 15 are the high compares for channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 1 | Count strobe, used in source mode 8 |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_lo | output | 4 | PWM outputs driven by the low counter |
| pwm_hi | output | 4 | PWM outputs driven by the high counter |
| unf_lo | output | 1 | Low counter underflow pulse |
| unf_hi | output | 1 | High counter underflow pulse |
| cmp_flag | output | 4 | Sticky match flags for the low-counter channels |
| cmp_evt | output | 4 | One-cycle match event pulses for the low-counter channels |

## Verification
The bench walks a table of period, compare and strobe-count cases across the wrap point, with compare values of 0 and compare values above the period. A design that compared with `<` instead of `<=`, or that reloaded one tick late, would give the wrong output level in several rows.

Directed cases check the following:
- Strobes are ignored while the source is stopped; a design that ignored the source code would count them.
- The first tick arrives at an exact cycle under divide-by-1, divide-by-4 and divide-by-1024; an off-by-one divider would shift it.
- A flag set and a software clear can land in the same cycle, and the set must win; a design that got this wrong would lose the match.
- A match on a high-counter compare must not leak into the low flags.

// File: rtl/spt_pkg.sv
package spt_pkg;

  // Clock source codes
  typedef enum logic [3:0] {
    SRC_OFF     = 4'd0,
    SRC_DIV1    = 4'd1,
    SRC_DIV2    = 4'd2,
    SRC_DIV4    = 4'd3,
    SRC_DIV8    = 4'd4,
    SRC_DIV64   = 4'd5,
    SRC_DIV256  = 4'd6,
    SRC_DIV1024 = 4'd7,
    SRC_EVENT   = 4'd8
  } src_e;

  localparam int SRC_W     = 4;
  localparam int MAX_SHIFT = 10;

  // Fixed register addresses (compare block lives in the upper half)
  localparam int ADDR_SRC   = 0;
  localparam int ADDR_CLR   = 1;
  localparam int ADDR_LD_LO = 2;
  localparam int ADDR_LD_HI = 3;
  localparam int ADDR_PR_LO = 4;
  localparam int ADDR_PR_HI = 5;

  // log2 of the clock divisor selected by a source code
  function automatic int unsigned div_shift(input logic [SRC_W-1:0] s);
    case (s)
      SRC_DIV2:    return 1;
      SRC_DIV4:    return 2;
      SRC_DIV8:    return 3;
      SRC_DIV64:   return 6;
      SRC_DIV256:  return 8;
      SRC_DIV1024: return 10;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/spt_tick_gen.sv
module spt_tick_gen
  import spt_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  input  logic             evt,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             run;
  logic             ev_mode;

  always_comb begin
    run     = (src >= SRC_DIV1) && (src <= SRC_DIV1024);
    ev_mode = (src == SRC_EVENT);
    mask    = PRE_W'((32'd1 << div_shift(src)) - 32'd1);
    if (ev_mode)
      tick = evt;
    else
      tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)
      pre_q <= '0;
    else
      pre_q <= pre_q + 1'b1;
  end

  // R6
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_OFF || src > SRC_EVENT) |-> !tick);

  // R7
  div_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> (pre_q == '0));

endmodule

// File: rtl/spt_regfile.sv
module spt_regfile
  import spt_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  output logic [SRC_W-1:0]        src,
  output logic [CW-1:0]           per_lo,
  output logic [CW-1:0]           per_hi,
  output logic [NCH-1:0][CW-1:0]  cmp_lo,
  output logic [NCH-1:0][CW-1:0]  cmp_hi,
  output logic                    ld_lo,
  output logic                    ld_hi,
  output logic [CW-1:0]           ld_val,
  output logic [NCH-1:0]          clr
);

  localparam int CMP_LO_BASE = 1 << (AW - 1);
  localparam int CMP_HI_BASE = CMP_LO_BASE + NCH;

  function automatic logic hit(input int a);
    return wr_en && (wr_addr == AW'(a));
  endfunction

  assign ld_lo  = hit(ADDR_LD_LO);
  assign ld_hi  = hit(ADDR_LD_HI);
  assign ld_val = wr_data;
  assign clr    = hit(ADDR_CLR) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src    <= SRC_OFF;
      per_lo <= '1;
      per_hi <= '1;
    end else begin
      if (hit(ADDR_SRC))   src    <= wr_data[SRC_W-1:0];
      if (hit(ADDR_PR_LO)) per_lo <= wr_data;
      if (hit(ADDR_PR_HI)) per_hi <= wr_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_lo[c] <= '0;
        cmp_hi[c] <= '0;
      end else begin
        if (hit(CMP_LO_BASE + c)) cmp_lo[c] <= wr_data;
        if (hit(CMP_HI_BASE + c)) cmp_hi[c] <= wr_data;
      end
    end
  end

  // R12
  period_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(ADDR_PR_LO)) |=> (per_lo == $past(wr_data)));

endmodule

// File: rtl/spt_down_counter.sv
module spt_down_counter #(
  parameter int CW  = 8,
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   load,
  input  logic [CW-1:0]          load_val,
  input  logic [CW-1:0]          per,
  input  logic [NCH-1:0][CW-1:0] cmp,
  output logic [CW-1:0]          cnt,
  output logic [NCH-1:0]         pwm,
  output logic                   unf
);

  logic at_zero;
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      unf <= 1'b0;
    end else begin
      unf <= tick && !load && at_zero;
      if (load)
        cnt <= load_val;
      else if (tick)
        cnt <= at_zero ? per : cnt - 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pwm
    assign pwm[c] = (cnt <= cmp[c]);
  end

  // R3
  unf_source_chk: assert property (@(posedge clk) disable iff (rst)
    unf |-> ($past(tick) && !$past(load) && $past(cnt) == '0));

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && at_zero) |=> (cnt == $past(per)));

endmodule

// File: rtl/spt_match_flags.sv
module spt_match_flags #(
  parameter int CW  = 8,
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   load,
  input  logic [CW-1:0]          cnt,
  input  logic [NCH-1:0][CW-1:0] cmp,
  input  logic [NCH-1:0]         clr,
  output logic [NCH-1:0]         flag,
  output logic [NCH-1:0]         evt
);

  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick && !load;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic set_c;
    assign set_c = tick_q && (cnt == cmp[c]);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag[c] <= 1'b0;
        evt[c]  <= 1'b0;
      end else begin
        flag[c] <= set_c || (flag[c] && !clr[c]);
        evt[c]  <= set_c;
      end
    end

    // R9
    flag_evt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[c]) |-> evt[c]);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag[c] && !clr[c]) |=> flag[c]);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[c] && !tick_q) |=> !flag[c]);
  end

endmodule

// File: rtl/spt_dual_pwm.sv
module spt_dual_pwm
  import spt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4,
  parameter int ADR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_strobe,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [N_CH-1:0]  pwm_lo,
  output logic [N_CH-1:0]  pwm_hi,
  output logic             unf_lo,
  output logic             unf_hi,
  output logic [N_CH-1:0]  cmp_flag,
  output logic [N_CH-1:0]  cmp_evt
);

  logic [SRC_W-1:0]            src;
  logic [CNT_W-1:0]            per_lo, per_hi;
  logic [N_CH-1:0][CNT_W-1:0]  cmp_lo, cmp_hi;
  logic                        ld_lo, ld_hi;
  logic [CNT_W-1:0]            ld_val;
  logic [N_CH-1:0]             clr;
  logic                        tick;
  logic [CNT_W-1:0]            cnt_lo, cnt_hi;

  spt_regfile #(.CW(CNT_W), .NCH(N_CH), .AW(ADR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src(src), .per_lo(per_lo), .per_hi(per_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_val(ld_val), .clr(clr)
  );

  spt_tick_gen #(.PRE_W(MAX_SHIFT)) u_tick (
    .clk(clk), .rst(rst), .src(src), .evt(evt_strobe), .tick(tick)
  );

  spt_down_counter #(.CW(CNT_W), .NCH(N_CH)) u_cnt_lo (
    .clk(clk), .rst(rst), .tick(tick), .load(ld_lo), .load_val(ld_val),
    .per(per_lo), .cmp(cmp_lo), .cnt(cnt_lo), .pwm(pwm_lo), .unf(unf_lo)
  );

  spt_down_counter #(.CW(CNT_W), .NCH(N_CH)) u_cnt_hi (
    .clk(clk), .rst(rst), .tick(tick), .load(ld_hi), .load_val(ld_val),
    .per(per_hi), .cmp(cmp_hi), .cnt(cnt_hi), .pwm(pwm_hi), .unf(unf_hi)
  );

  spt_match_flags #(.CW(CNT_W), .NCH(N_CH)) u_flags (
    .clk(clk), .rst(rst), .tick(tick), .load(ld_lo), .cnt(cnt_lo),
    .cmp(cmp_lo), .clr(clr), .flag(cmp_flag), .evt(cmp_evt)
  );

  // R2
  lo_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_lo && cnt_lo != '0) |=> (cnt_lo == $past(cnt_lo) - 1'b1));

  // R2
  hi_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_hi && cnt_hi != '0) |=> (cnt_hi == $past(cnt_hi) - 1'b1));

  // R12
  hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_hi |=> (cnt_hi == $past(wr_data)));

  // R12
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_lo) |=> $stable(cnt_lo));

endmodule

// File: tb/sim_spt_dual_pwm.sv
module sim_spt_dual_pwm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_strobe = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_lo, pwm_hi, cmp_flag, cmp_evt;
  logic       unf_lo, unf_hi;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  spt_dual_pwm u0 (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_lo(pwm_lo), .pwm_hi(pwm_hi),
    .unf_lo(unf_lo), .unf_hi(unf_hi), .cmp_flag(cmp_flag), .cmp_evt(cmp_evt)
  );

  // {period, compare, strobes after loading counter with period, expected pwm_lo[0]}
  localparam logic [31:0] VEC [10] = '{
    {8'd10,  8'd5,   8'd3,  8'd0},
    {8'd10,  8'd5,   8'd5,  8'd1},
    {8'd10,  8'd5,   8'd10, 8'd1},
    {8'd10,  8'd5,   8'd11, 8'd0},
    {8'd10,  8'd0,   8'd9,  8'd0},
    {8'd10,  8'd0,   8'd10, 8'd1},
    {8'd10,  8'd11,  8'd4,  8'd1},
    {8'd255, 8'd200, 8'd60, 8'd1},
    {8'd3,   8'd2,   8'd6,  8'd1},
    {8'd3,   8'd1,   8'd4,  8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    evt_strobe = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_lo", pwm_lo, 4'hF);
    chk("R1 pwm_hi", pwm_hi, 4'hF);
    chk("R1 flags", cmp_flag, 4'h0);
    chk("R1 unf", {unf_lo, unf_hi}, 2'b00);

    // R1 periods reset to FF, R3 underflow on both, R8 event mode
    wr(4'd0, 8'd8);
    strobe();
    chk("R3 unf both", {unf_lo, unf_hi}, 2'b11);
    chk("R1 period FF reload", pwm_lo, 4'h0);
    @(negedge clk);
    chk("R3 unf one cycle", {unf_lo, unf_hi}, 2'b00);
    chk("R9 no flag without match", cmp_flag, 4'h0);

    // R6 stopped source ignores strobes
    wr(4'd0, 8'd0);
    wr(4'd8, 8'd5);
    wr(4'd2, 8'd10);
    chk("R12 load+cmp immediate", pwm_lo[0], 1'b0);
    repeat (5) strobe();
    chk("R6 stopped", pwm_lo[0], 1'b0);
    wr(4'd0, 8'd15);
    repeat (5) strobe();
    chk("R6 code 15 stopped", pwm_lo[0], 1'b0);
    wr(4'd0, 8'd8);

    // R2 R4 R5 R8 vector table
    for (int i = 0; i < 10; i++) begin
      wr(4'd4, VEC[i][31:24]);
      wr(4'd8, VEC[i][23:16]);
      wr(4'd2, VEC[i][31:24]);
      repeat (int'(VEC[i][15:8])) strobe();
      chk($sformatf("R2/R4/R5 vector %0d", i), pwm_lo[0], VEC[i][0]);
    end

    // R3 independent underflow
    wr(4'd3, 8'd100);
    wr(4'd4, 8'd2);
    wr(4'd2, 8'd0);
    strobe();
    chk("R3 low only", {unf_lo, unf_hi}, 2'b10);
    wr(4'd3, 8'd0);
    wr(4'd2, 8'd50);
    strobe();
    chk("R3 high only", {unf_lo, unf_hi}, 2'b01);

    // R9 compare flag, R10 clear
    wr(4'd8, 8'd250);
    wr(4'd9, 8'd5);
    wr(4'd10, 8'd250);
    wr(4'd11, 8'd250);
    wr(4'd1, 8'h0F);
    wr(4'd4, 8'd20);
    wr(4'd2, 8'd7);
    chk("R10 all clear", cmp_flag, 4'h0);
    strobe();
    strobe();
    chk("R9 not yet", cmp_flag, 4'h0);
    @(negedge clk);
    chk("R9 flag set", cmp_flag, 4'b0010);
    chk("R9 evt pulse", cmp_evt, 4'b0010);
    @(negedge clk);
    chk("R9 evt one cycle", cmp_evt, 4'b0000);
    strobe();
    chk("R9 sticky", cmp_flag, 4'b0010);

    // R11 high compares do not flag
    for (int c = 12; c < 16; c++) wr(4'(c), 8'd8);
    wr(4'd3, 8'd9);
    strobe();
    @(negedge clk);
    chk("R11 high match pwm", pwm_hi, 4'hF);
    chk("R11 flags unchanged", cmp_flag, 4'b0010);
    chk("R11 no evt", cmp_evt, 4'b0000);

    wr(4'd1, 8'h02);
    chk("R10 w1c", cmp_flag, 4'b0000);

    // R10 set wins over clear
    wr(4'd2, 8'd6);
    @(negedge clk);
    evt_strobe = 1'b1;
    @(negedge clk);
    evt_strobe = 1'b0;
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 set wins", cmp_flag, 4'b0010);

    // R7 divide by 4
    wr(4'd0, 8'd0);
    wr(4'd8, 8'd97);
    wr(4'd2, 8'd100);
    wr(4'd0, 8'd3);
    repeat (11) @(negedge clk);
    chk("R7 div4 before", pwm_lo[0], 1'b0);
    @(negedge clk);
    chk("R7 div4 third tick", pwm_lo[0], 1'b1);

    // R7 divide by 1
    wr(4'd0, 8'd0);
    wr(4'd8, 8'd7);
    wr(4'd2, 8'd10);
    wr(4'd0, 8'd1);
    repeat (2) @(negedge clk);
    chk("R7 div1 before", pwm_lo[0], 1'b0);
    @(negedge clk);
    chk("R7 div1 third tick", pwm_lo[0], 1'b1);

    // R7 divide by 1024
    wr(4'd0, 8'd0);
    wr(4'd8, 8'd9);
    wr(4'd2, 8'd10);
    wr(4'd0, 8'd7);
    repeat (1023) @(negedge clk);
    chk("R7 div1024 before", pwm_lo[0], 1'b0);
    @(negedge clk);
    chk("R7 div1024 first tick", pwm_lo[0], 1'b1);

    finish_run();
  end

endmodule